// File: doc/BRIEF.md
# Delta Modulation Sample Voice

This block plays back a one-bit delta-modulated waveform. It reads sample bytes from the processor's memory space through a simple request/acknowledge port and holds one byte in a buffer. A shifter drains each byte starting at its least significant bit. Every consumed bit moves a 6-bit output level one step: up for a 1, down for a 0. The level stops at the ends of its range instead of wrapping. A rate divider chooses how many clocks pass between consumed bits, using one of sixteen fixed divider values.

Software programs the voice through four byte-wide registers and a separate enable strobe. The registers set the rate, the loop and interrupt options, the level, the start address and the length. A sample either plays once or restarts from its start address without a gap. When a single-shot sample fetches its last byte, the voice can raise an interrupt flag, which stays set until the next write to the control register. The output level goes to an external converter.

Top module: `delta_sample_voice`

## Requirements
- R1: After reset the level is 0, and `irq`, `mem_req` and `busy` are all low.
- R2: A write with `reg_sel`=1 loads `reg_wdata[6:1]` into the level on the next cycle. This write takes priority over a bit step in the same cycle.
- R3: Setting the enable (`en_wr`=1, `en_val`=1) while `busy` is low does three things. It loads the byte count with 16 × (`reg_sel`=3 value) + 1. It loads the fetch address with 0xC000 + 16 × (`reg_sel`=2 value). It raises `busy` on the next cycle. Each accepted byte then advances the address by one and lowers the count by one. `busy` is high while the count is not zero.
- R4: Setting the enable while `busy` is high has no effect: the fetch address and the count carry on.
- R5: Clearing the enable (`en_wr`=1, `en_val`=0) zeroes the count. On the next cycle `busy` and `mem_req` are low. Bits already fetched still play out.
- R6: The control register is `reg_sel`=0. Bits 3:0 are the rate index, bit 6 is loop, and bit 7 is the interrupt enable. Divider values in clocks, for index 0 to 15: 428, 380, 340, 320, 286, 254, 226, 214, 190, 160, 142, 128, 106, 84, 72, 54. Each value is divided by `RATE_DIV`. One bit is consumed per divider period.
- R7: Bits are consumed least significant first. A 1 adds one to the level and a 0 subtracts one.
- R8: The level saturates at 63 and at 0.
- R9: With loop off, accepting the last byte drops `busy`. If the interrupt enable is set, the same edge sets `irq`. With the interrupt enable clear, `irq` stays low.
- R10: With loop on, accepting the last byte reloads the start address and the full count. `busy` stays high and `irq` is not set.
- R11: Any write with `reg_sel`=0 clears `irq` on the next cycle.
- R12: `mem_req` is high whenever the buffer is empty and the count is not zero. Once raised, `mem_req` stays high with `mem_addr` unchanged until `mem_ack`. The only exception is a clearing of the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 control, 1 level, 2 start, 3 length |
| reg_wdata | input | 8 | Register write data |
| en_wr | input | 1 | Enable bit write strobe |
| en_val | input | 1 | Enable bit value |
| mem_req | output | 1 | Sample byte read request |
| mem_addr | output | 16 | Sample byte address |
| mem_ack | input | 1 | Read accepted; `mem_rdata` valid |
| mem_rdata | input | 8 | Sample byte read data |
| level | output | 6 | Output level |
| irq | output | 1 | End-of-sample interrupt flag |
| busy | output | 1 | Bytes remain to be fetched |

## Verification
The checks assume that `mem_ack` is raised only while `mem_req` is high, and that `mem_rdata` is valid in that same cycle. The bench's memory model derives its acknowledge from the current request and inserts a wait state on every third cycle, so the stimulus stays within this assumption. The checks also assume that inputs change only between clock edges. The bench drives every input at the falling edge, so register writes and enable strobes never collide with the sampling edge.

// File: rtl/dsv_pkg.sv
package dsv_pkg;

   localparam int BYTE_W      = 8;
   localparam int RATE_COUNT  = 16;
   localparam int RATE_MAX    = 428;
   localparam int RATE_MIN    = 54;

   typedef enum logic [1:0] {
      SEL_CTRL   = 2'd0,
      SEL_LEVEL  = 2'd1,
      SEL_START  = 2'd2,
      SEL_LENGTH = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic       irq_en;
      logic       loop;
      logic [3:0] rate;
   } ctrl_t;

   // Clock count between consumed bits for each rate index.
   function automatic int unsigned rate_clocks(input logic [3:0] idx);
      int unsigned v;
      case (idx)
         4'd0:  v = 428;
         4'd1:  v = 380;
         4'd2:  v = 340;
         4'd3:  v = 320;
         4'd4:  v = 286;
         4'd5:  v = 254;
         4'd6:  v = 226;
         4'd7:  v = 214;
         4'd8:  v = 190;
         4'd9:  v = 160;
         4'd10: v = 142;
         4'd11: v = 128;
         4'd12: v = 106;
         4'd13: v = 84;
         4'd14: v = 72;
         default: v = 54;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/dsv_regs.sv
module dsv_regs
   import dsv_pkg::*;
#(
   parameter int LVL_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [1:0]       sel,
   input  logic [7:0]       wdata,
   output ctrl_t            ctrl,
   output logic [7:0]       start_code,
   output logic [7:0]       len_code,
   output logic             ctrl_wr,
   output logic             lvl_wr,
   output logic [LVL_W-1:0] lvl_val
);

   logic unused_wdata_bits;
   assign unused_wdata_bits = ^wdata[5:4];

   assign ctrl_wr = wr && (sel == SEL_CTRL);
   assign lvl_wr  = wr && (sel == SEL_LEVEL);
   assign lvl_val = wdata[LVL_W:1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl       <= '0;
         start_code <= '0;
         len_code   <= '0;
      end else if (wr) begin
         case (sel)
            SEL_CTRL: begin
               ctrl.irq_en <= wdata[7];
               ctrl.loop   <= wdata[6];
               ctrl.rate   <= wdata[3:0];
            end
            SEL_START:  start_code <= wdata;
            SEL_LENGTH: len_code   <= wdata;
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/dsv_timer.sv
module dsv_timer
   import dsv_pkg::*;
#(
   parameter int RATE_DIV = 1,
   parameter int TMR_W    = $clog2(RATE_MAX)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [3:0] rate,
   output logic       tick
);

   logic [TMR_W-1:0] cnt;
   logic [TMR_W-1:0] reload;

   always_comb begin
      reload = TMR_W'(rate_clocks(rate) / RATE_DIV - 1);
   end

   assign tick = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= reload;
      end else begin
         cnt <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/dsv_fetch.sv
module dsv_fetch
   import dsv_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter logic [31:0] BASE_ADDR = 32'h0000_C000,
   parameter int          ADDR_LG   = 4,
   parameter int          LEN_LG    = 4,
   parameter int          REM_W     = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr,
   input  logic              en_val,
   input  logic [7:0]        start_code,
   input  logic [7:0]        len_code,
   input  logic              loop,
   input  logic              irq_en,
   input  logic              ctrl_wr,
   input  logic              take,
   input  logic              mem_ack,
   input  logic [BYTE_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              buf_full,
   output logic [BYTE_W-1:0] buf_data,
   output logic              busy,
   output logic              irq
);

   logic [REM_W-1:0]  remain;
   logic [ADDR_W-1:0] start_addr;
   logic [REM_W-1:0]  start_len;
   logic              accept;
   logic              last_byte;
   logic              stop_req;
   logic              start_req;

   assign start_addr = ADDR_W'(BASE_ADDR) + (ADDR_W'(start_code) << ADDR_LG);
   assign start_len  = (REM_W'(len_code) << LEN_LG) + REM_W'(1);

   assign busy      = (remain != '0);
   assign mem_req   = !buf_full && busy;
   assign accept    = mem_req && mem_ack;
   assign last_byte = accept && (remain == REM_W'(1));
   assign stop_req  = en_wr && !en_val;
   assign start_req = en_wr && en_val && !busy;

   // Count and address: enable strobe outranks a byte acceptance.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         remain   <= '0;
         mem_addr <= ADDR_W'(BASE_ADDR);
      end else if (stop_req) begin
         remain   <= '0;
      end else if (start_req) begin
         remain   <= start_len;
         mem_addr <= start_addr;
      end else if (accept) begin
         if (last_byte && loop) begin
            remain   <= start_len;
            mem_addr <= start_addr;
         end else begin
            remain   <= remain - 1'b1;
            mem_addr <= mem_addr + 1'b1;
         end
      end
   end

   // One-byte holding buffer between memory and shifter.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_full <= 1'b0;
         buf_data <= '0;
      end else if (accept) begin
         buf_full <= 1'b1;
         buf_data <= mem_rdata;
      end else if (take) begin
         buf_full <= 1'b0;
      end
   end

   // End-of-sample flag: a control write clears it and wins.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else if (ctrl_wr) begin
         irq <= 1'b0;
      end else if (last_byte && !loop && irq_en) begin
         irq <= 1'b1;
      end
   end

endmodule

// File: rtl/dsv_output.sv
module dsv_output
   import dsv_pkg::*;
#(
   parameter int LVL_W    = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              buf_full,
   input  logic [BYTE_W-1:0] buf_data,
   input  logic              lvl_wr,
   input  logic [LVL_W-1:0]  lvl_val,
   output logic              take,
   output logic [LVL_W-1:0]  level
);

   localparam int                CNT_W   = $clog2(BYTE_W + 1);
   localparam logic [LVL_W-1:0]  LVL_TOP = '1;
   localparam logic [LVL_W-1:0]  LVL_BOT = '0;

   logic [BYTE_W-1:0] shreg;
   logic [CNT_W-1:0]  left;
   logic              step;
   logic [LVL_W-1:0]  stepped;

   assign take = (left == '0) && buf_full;
   assign step = tick && (left != '0);

   generate
      if (SATURATE) begin : g_sat
         always_comb begin
            if (shreg[0]) begin
               stepped = (level == LVL_TOP) ? level : level + 1'b1;
            end else begin
               stepped = (level == LVL_BOT) ? level : level - 1'b1;
            end
         end
      end else begin : g_wrap
         always_comb begin
            stepped = shreg[0] ? level + 1'b1 : level - 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '0;
         left  <= '0;
      end else if (take) begin
         shreg <= buf_data;
         left  <= CNT_W'(BYTE_W);
      end else if (step) begin
         shreg <= shreg >> 1;
         left  <= left - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         level <= '0;
      end else if (lvl_wr) begin
         level <= lvl_val;
      end else if (step) begin
         level <= stepped;
      end
   end

endmodule

// File: rtl/delta_sample_voice.sv
module delta_sample_voice
   import dsv_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          LVL_W     = 6,
   parameter int          RATE_DIV  = 1,
   parameter logic [31:0] BASE_ADDR = 32'h0000_C000,
   parameter int          ADDR_LG   = 4,
   parameter int          LEN_LG    = 4,
   parameter bit          SATURATE  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic              en_wr,
   input  logic              en_val,
   output logic              mem_req,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack,
   input  logic [7:0]        mem_rdata,
   output logic [LVL_W-1:0]  level,
   output logic              irq,
   output logic              busy
);

   localparam int REM_W = $clog2((255 << LEN_LG) + 2);
   localparam int TMR_W = $clog2(RATE_MAX);

   if (LVL_W < 2 || LVL_W > 7) begin : g_bad_lvl
      $error("LVL_W must lie in 2..7");
   end
   if (RATE_DIV < 1 || RATE_DIV > RATE_MIN) begin : g_bad_div
      $error("RATE_DIV must lie in 1..54");
   end
   if (ADDR_W < 16) begin : g_bad_addr
      $error("ADDR_W must be at least 16");
   end

   ctrl_t             ctrl;
   logic [7:0]        start_code;
   logic [7:0]        len_code;
   logic              ctrl_wr;
   logic              lvl_wr;
   logic [LVL_W-1:0]  lvl_val;
   logic              tick;
   logic              take;
   logic              buf_full;
   logic [BYTE_W-1:0] buf_data;

   dsv_regs #(.LVL_W(LVL_W)) regs_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (reg_wr),
      .sel        (reg_sel),
      .wdata      (reg_wdata),
      .ctrl       (ctrl),
      .start_code (start_code),
      .len_code   (len_code),
      .ctrl_wr    (ctrl_wr),
      .lvl_wr     (lvl_wr),
      .lvl_val    (lvl_val)
   );

   dsv_timer #(.RATE_DIV(RATE_DIV), .TMR_W(TMR_W)) timer_i (
      .clk   (clk),
      .rst_n (rst_n),
      .rate  (ctrl.rate),
      .tick  (tick)
   );

   dsv_fetch #(
      .ADDR_W    (ADDR_W),
      .BASE_ADDR (BASE_ADDR),
      .ADDR_LG   (ADDR_LG),
      .LEN_LG    (LEN_LG),
      .REM_W     (REM_W)
   ) fetch_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_wr      (en_wr),
      .en_val     (en_val),
      .start_code (start_code),
      .len_code   (len_code),
      .loop       (ctrl.loop),
      .irq_en     (ctrl.irq_en),
      .ctrl_wr    (ctrl_wr),
      .take       (take),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_addr   (mem_addr),
      .buf_full   (buf_full),
      .buf_data   (buf_data),
      .busy       (busy),
      .irq        (irq)
   );

   dsv_output #(.LVL_W(LVL_W), .SATURATE(SATURATE)) output_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .buf_full (buf_full),
      .buf_data (buf_data),
      .lvl_wr   (lvl_wr),
      .lvl_val  (lvl_val),
      .take     (take),
      .level    (level)
   );

endmodule

// File: rtl/dsv_checker.sv
module dsv_checker #(
   parameter int LVL_W  = 6,
   parameter int ADDR_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [1:0]        reg_sel,
   input logic [7:0]        reg_wdata,
   input logic              en_wr,
   input logic              en_val,
   input logic              mem_req,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              mem_ack,
   input logic [LVL_W-1:0]  level,
   input logic              irq,
   input logic              busy
);

   // R7
   level_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr && reg_sel == 2'd1) |=>
         ((int'(level) - int'($past(level))) inside {-1, 0, 1}));

   // R2
   level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd1) |=> (level == $past(reg_wdata[LVL_W:1])));

   // R12
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack && !(en_wr && !en_val)) |=> (mem_req && $stable(mem_addr)));

   // R11
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_sel == 2'd0) |=> !irq);

   // R9
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> ($past(mem_ack) && !busy));

   // R5
   stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_wr && !en_val) |=> (!busy && !mem_req));

endmodule

bind delta_sample_voice dsv_checker #(.LVL_W(LVL_W), .ADDR_W(ADDR_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_wr    (reg_wr),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .en_wr     (en_wr),
   .en_val    (en_val),
   .mem_req   (mem_req),
   .mem_addr  (mem_addr),
   .mem_ack   (mem_ack),
   .level     (level),
   .irq       (irq),
   .busy      (busy)
);

// File: tb/delta_sample_voice_tb.sv
module delta_sample_voice_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int RATE_DIV   = 4;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [1:0]  reg_sel = 2'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic        en_wr = 1'b0;
   logic        en_val = 1'b0;
   logic        mem_req;
   logic [15:0] mem_addr;
   logic        mem_ack = 1'b0;
   logic [7:0]  mem_rdata = 8'd0;
   logic [5:0]  level;
   logic        irq;
   logic        busy;

   int n_checks = 0;
   int n_fail   = 0;
   int cycle    = 0;
   int stall    = 0;
   int fill     = 0;

   // reference state
   int  m_level, m_rem, m_addr, m_tmr, m_rate, m_startc, m_lenc;
   bit  m_irq, m_irqen, m_loop, m_bfull;
   logic [7:0] m_buf;
   bit  m_q[$];
   bit  acc, tk, tk_tick, b, lvl_w;

   always #(CLK_PERIOD / 2) clk = ~clk;

   delta_sample_voice #(.RATE_DIV(RATE_DIV)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .en_wr     (en_wr),
      .en_val    (en_val),
      .mem_req   (mem_req),
      .mem_addr  (mem_addr),
      .mem_ack   (mem_ack),
      .mem_rdata (mem_rdata),
      .level     (level),
      .irq       (irq),
      .busy      (busy)
   );

   function automatic int rate_tab(input int idx);
      int t[16] = '{428, 380, 340, 320, 286, 254, 226, 214,
                    190, 160, 142, 128, 106, 84, 72, 54};
      return t[idx];
   endfunction

   function automatic logic [7:0] fill_byte(input logic [15:0] a);
      case (fill)
         1:       return 8'hFF;
         2:       return 8'h00;
         default: return a[7:0] ^ 8'hA5;
      endcase
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   // Reference model, advanced on each rising edge.
   always @(posedge clk) begin
      cycle++;
      if (!rst_n) begin
         m_level = 0; m_irq = 0; m_irqen = 0; m_loop = 0; m_rate = 0;
         m_startc = 0; m_lenc = 0; m_rem = 0; m_addr = 16'hC000;
         m_bfull = 0; m_buf = 8'h00; m_q.delete(); m_tmr = 0;
      end else begin
         acc     = (!m_bfull && m_rem != 0) && mem_ack;
         tk      = (m_q.size() == 0) && m_bfull;
         tk_tick = (m_tmr == 0);
         lvl_w   = reg_wr && reg_sel == 2'd1;
         if (tk) begin
            for (int i = 0; i < 8; i++) m_q.push_back(m_buf[i]);
         end else if (tk_tick && m_q.size() > 0) begin
            b = m_q.pop_front();
            if (!lvl_w) m_level = b ? ((m_level < 63) ? m_level + 1 : 63)
                                    : ((m_level > 0) ? m_level - 1 : 0);
         end
         if (lvl_w) m_level = int'(reg_wdata[6:1]);
         if (acc) begin m_bfull = 1; m_buf = mem_rdata; end
         else if (tk) m_bfull = 0;
         if (reg_wr && reg_sel == 2'd0) m_irq = 0;
         else if (acc && m_rem == 1 && !m_loop && m_irqen) m_irq = 1;
         if (en_wr && !en_val) m_rem = 0;
         else if (en_wr && en_val && m_rem == 0) begin
            m_rem = m_lenc * 16 + 1; m_addr = 16'hC000 + m_startc * 16;
         end else if (acc) begin
            if (m_rem == 1 && m_loop) begin
               m_rem = m_lenc * 16 + 1; m_addr = 16'hC000 + m_startc * 16;
            end else begin
               m_rem--; m_addr = (m_addr + 1) & 16'hFFFF;
            end
         end
         if (tk_tick) m_tmr = rate_tab(m_rate) / RATE_DIV - 1;
         else m_tmr--;
         if (reg_wr) begin
            case (reg_sel)
               2'd0: begin m_irqen = reg_wdata[7]; m_loop = reg_wdata[6]; m_rate = int'(reg_wdata[3:0]); end
               2'd2: m_startc = int'(reg_wdata);
               2'd3: m_lenc = int'(reg_wdata);
               default: ;
            endcase
         end
      end
      if (cycle > WATCHDOG) begin
         n_fail++;
         $display("FAIL watchdog R1 actual=%0d expected=%0d", cycle, WATCHDOG);
         finish_run();
      end
   end

   // Per-cycle comparison and memory responder, on the falling edge.
   always @(negedge clk) begin
      if (rst_n) begin
         check("R7 R8 level", int'(level), m_level);
         check("R9 irq", int'(irq), int'(m_irq));
         check("R12 mem_req", int'(mem_req), int'(!m_bfull && m_rem != 0));
         check("R3 busy", int'(busy), int'(m_rem != 0));
         if (mem_req) check("R3 mem_addr", int'(mem_addr), m_addr);
      end
      stall++;
      mem_ack   = mem_req && (stall % 3 != 2);
      mem_rdata = fill_byte(mem_addr);
   end

   task automatic wr_reg(input logic [1:0] s, input logic [7:0] d);
      @(negedge clk); reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic set_en(input logic v);
      @(negedge clk); en_wr = 1'b1; en_val = v;
      @(negedge clk); en_wr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      int t1, t2, t3;
      logic [5:0] prev;
      idle(4);
      rst_n = 1'b1;
      idle(1);
      check("R1 level", int'(level), 0);
      check("R1 irq", int'(irq), 0);
      check("R1 mem_req", int'(mem_req), 0);
      check("R1 busy", int'(busy), 0);

      // single shot, no interrupt, fastest rate
      wr_reg(2'd0, 8'h0F);
      wr_reg(2'd1, 8'h40);
      check("R2 level load", int'(level), 32);
      wr_reg(2'd2, 8'h10);
      wr_reg(2'd3, 8'h01);
      set_en(1'b1);
      check("R3 start address", int'(mem_addr), 16'hC100);
      check("R3 busy", int'(busy), 1);
      idle(500);
      set_en(1'b1);
      check("R4 busy kept", int'(busy), 1);
      check("R4 address advanced", int'(mem_addr > 16'hC100), 1);
      idle(2200);
      check("R9 done", int'(busy), 0);
      check("R9 no irq when disabled", int'(irq), 0);

      // single shot with interrupt
      wr_reg(2'd0, 8'h8F);
      wr_reg(2'd2, 8'h00);
      wr_reg(2'd3, 8'h00);
      set_en(1'b1);
      idle(200);
      check("R9 busy low", int'(busy), 0);
      check("R9 irq set", int'(irq), 1);
      wr_reg(2'd0, 8'h0F);
      check("R11 irq cleared", int'(irq), 0);

      // looping, saturation at top
      fill = 1;
      wr_reg(2'd0, 8'h4F);
      wr_reg(2'd2, 8'h20);
      wr_reg(2'd1, 8'h7C);
      set_en(1'b1);
      idle(400);
      check("R10 still busy", int'(busy), 1);
      check("R10 no irq", int'(irq), 0);
      check("R8 top", int'(level), 63);
      fill = 2;
      wr_reg(2'd1, 8'h04);
      idle(800);
      check("R8 bottom", int'(level), 0);
      check("R10 address reload", int'(mem_addr), 16'hC200);
      set_en(1'b0);
      check("R5 busy cleared", int'(busy), 0);
      check("R5 no request", int'(mem_req), 0);
      idle(300);

      // rate 0 spacing
      fill = 1;
      wr_reg(2'd0, 8'h40);
      wr_reg(2'd1, 8'h14);
      set_en(1'b1);
      prev = level;
      while (level == prev) @(negedge clk);
      prev = level; t1 = cycle;
      while (level == prev) @(negedge clk);
      prev = level; t2 = cycle;
      while (level == prev) @(negedge clk);
      t3 = cycle;
      check("R6 bit period", t2 - t1, 428 / RATE_DIV);
      check("R6 bit period again", t3 - t2, 428 / RATE_DIV);
      check("R7 rising", int'(level), 13);
      set_en(1'b0);
      idle(20);
      finish_run();
   end

endmodule